// File: doc/BRIEF.md
# Eight-Line Vectored Interrupt Controller

This block gathers up to eight interrupt request lines and raises a single interrupt towards the processor. It keeps three registers: the requests it has captured, the levels now being serviced, and a mask. When the processor acknowledges, the block places a vector byte on its data output. That byte is a programmed base plus the index of the winning line. Line 0 has the highest priority and line 7 the lowest. A request is forwarded only when it is unmasked and outranks every level now in service, so a handler can be pre-empted only by a more urgent line.

Software sets the block up with an ordered series of setup words over a small synchronous host port. The port has a chip select, read and write strobes, one command-address bit and an 8-bit data path. The first word chooses the trigger style and tells the block which later words to expect. After that come the vector base, an optional cascade byte and an optional mode byte. The mode byte selects automatic or commanded end of service. Once the block is running, writes at the high address set the mask. Writes at the low address either end a service level or choose which status register a low-address read returns.

Top module: `irq_ctrl8`

## Requirements
- R1: After reset the block is not running: `proc_irq` is 0, the mask reads back 0xFF at address 1, and the request and service registers are 0.
- R2: A write at address 0 with bit 4 = 1 starts setup. It latches bit 3 (1 = level, 0 = edge), bit 1 (1 = single, 0 = cascaded) and bit 0 (1 = a mode byte follows). It clears the mask, the request and service registers and automatic mode, and selects the request register for reading. The next address-1 write is the vector base. One more address-1 write is consumed as the cascade byte only when bit 1 was 0. One more is taken as the mode byte only when bit 0 was 1. After that the block runs. Before it runs, `proc_irq` stays 0.
- R3: During an acknowledge (`iack` = 1) the data output carries base + n modulo 256, where n is the winning line, and `dout_en` is 1.
- R4: Among pending lines that are eligible, the lowest index wins. Repeated acknowledges therefore drain pending lines in ascending index order.
- R5: Mask bit n = 1 keeps line n out of `proc_irq` and out of selection. The request is still recorded and can be read back.
- R6: A pending line is eligible only if its index is lower than that of every bit set in the service register.
- R7: In commanded mode (mode byte bit 1 = 0) an acknowledge clears the winning request bit and sets the same bit in the service register.
- R8: In automatic mode (mode byte bit 1 = 1) an acknowledge leaves the service register unchanged. The service register stays 0.
- R9: While running, a write at address 0 with bits 7..5 = 001 and bits 4 and 3 = 0 clears the lowest-index bit set in the service register.
- R10: While running, a write at address 0 with bit 4 = 0, bit 3 = 1 and bit 1 = 1 selects what address-0 reads return: the request register if bit 0 = 0, the service register if bit 0 = 1. With bit 1 = 0 the selection is unchanged. Address-1 reads return the mask.
- R11: In edge mode a request bit sets on a 0-to-1 change of its line and stays set until acknowledged; a line held high does not set it again. In level mode the request bit follows the line one clock later.
- R12: An acknowledge with no eligible line returns base + 7 and changes neither the request register nor the service register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs | input | 1 | Chip select for host accesses |
| rd | input | 1 | Read strobe, qualified by cs |
| wr | input | 1 | Write strobe, qualified by cs, taken at the clock edge |
| addr_bit | input | 1 | Command address bit |
| din | input | 8 | Host write data |
| iack | input | 1 | Interrupt acknowledge from the processor, one cycle per acknowledge |
| irq_in | input | 8 | Request lines, line 0 most urgent |
| dout | output | 8 | Read data or vector byte |
| dout_en | output | 1 | High while dout carries read data or a vector |
| proc_irq | output | 1 | Interrupt request to the processor |

## Verification
The bench sweeps all 255 non-empty request patterns. Each one is drained by acknowledge-and-end pairs, so a priority encoder that picks the wrong end, or an end-of-service that clears the wrong bit, shows up as a vector out of order or a service register that never empties. It also walks all 256 mask values against a full set of pending lines, and nests a more urgent and a less urgent line under a line in service, which catches a resolver that ignores the service register. Each setup path is exercised (cascaded without a mode byte, single without a mode byte, single with level and automatic mode). A design that consumes the wrong number of words either writes the cascade byte into the mask or swallows the first mask write. Vector wrap past 0xFF, spurious acknowledges and a line held high in edge mode are probed to catch adders without wrap, state disturbed by a spurious acknowledge and edge detectors that re-fire on a level.

// File: rtl/irq_ctrl8_pkg.sv
package irq_ctrl8_pkg;
  localparam int unsigned LINES  = 8;
  localparam int unsigned IDX_W  = $clog2(LINES);
  localparam int unsigned BYTE_W = 8;

  typedef logic [LINES-1:0]  line_vec_t;
  typedef logic [IDX_W-1:0]  line_idx_t;
  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_BASE,
    SEQ_CASC,
    SEQ_MODE,
    SEQ_RUN
  } seq_state_t;

  // Isolate the lowest set bit (the most urgent line).
  function automatic line_vec_t pick_lowest(input line_vec_t v);
    return v & (~v + line_vec_t'(1));
  endfunction

  function automatic line_idx_t onehot_to_idx(input line_vec_t oh);
    line_idx_t r;
    r = '0;
    for (int i = 0; i < LINES; i++)
      if (oh[i]) r = line_idx_t'(i);
    return r;
  endfunction

  // Lines strictly more urgent than every level in service.
  function automatic line_vec_t above_service(input line_vec_t svc);
    if (svc == '0) return '1;
    return pick_lowest(svc) - line_vec_t'(1);
  endfunction

  function automatic byte_t vector_of(input byte_t base, input line_idx_t idx);
    return base + byte_t'(idx);
  endfunction
endpackage

// File: rtl/irq_ctrl8_cfg.sv
module irq_ctrl8_cfg
  import irq_ctrl8_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_stb,
  input  logic      addr_bit,
  input  byte_t     din,
  output logic      running,
  output logic      level_mode,
  output logic      auto_eoi,
  output byte_t     base,
  output line_vec_t mask,
  output logic      rd_svc,
  output logic      eoi_cmd,
  output logic      setup_clr
);
  localparam int unsigned B_START  = 4;
  localparam int unsigned B_LEVEL  = 3;
  localparam int unsigned B_SINGLE = 1;
  localparam int unsigned B_WANT_M = 0;
  localparam int unsigned B_AUTO   = 1;
  localparam int unsigned B_SELOP  = 3;
  localparam int unsigned B_SELEN  = 1;
  localparam int unsigned B_SELSV  = 0;
  localparam logic [2:0]  EOI_CODE = 3'b001;

  seq_state_t state_q;
  logic       single_q;
  logic       want_mode_q;
  logic       lo_write;
  logic       hi_write;
  logic       sel_write;

  assign lo_write  = wr_stb & ~addr_bit;
  assign hi_write  = wr_stb & addr_bit;
  assign setup_clr = lo_write & din[B_START];
  assign running   = (state_q == SEQ_RUN);
  assign sel_write = lo_write & ~din[B_START] & din[B_SELOP] & din[B_SELEN] & running;
  assign eoi_cmd   = lo_write & ~din[B_START] & ~din[B_SELOP] &
                     (din[7:5] == EOI_CODE) & running;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= SEQ_IDLE;
      level_mode  <= 1'b0;
      single_q    <= 1'b1;
      want_mode_q <= 1'b0;
      auto_eoi    <= 1'b0;
      base        <= '0;
      mask        <= '1;
      rd_svc      <= 1'b0;
    end else if (setup_clr) begin
      state_q     <= SEQ_BASE;
      level_mode  <= din[B_LEVEL];
      single_q    <= din[B_SINGLE];
      want_mode_q <= din[B_WANT_M];
      auto_eoi    <= 1'b0;
      mask        <= '0;
      rd_svc      <= 1'b0;
    end else if (hi_write) begin
      unique case (state_q)
        SEQ_BASE: begin
          base <= din;
          if (!single_q)        state_q <= SEQ_CASC;
          else if (want_mode_q) state_q <= SEQ_MODE;
          else                  state_q <= SEQ_RUN;
        end
        SEQ_CASC: state_q <= want_mode_q ? SEQ_MODE : SEQ_RUN;
        SEQ_MODE: begin
          auto_eoi <= din[B_AUTO];
          state_q  <= SEQ_RUN;
        end
        SEQ_RUN:  mask <= din;
        default:  state_q <= state_q;
      endcase
    end else if (sel_write) begin
      rd_svc <= din[B_SELSV];
    end
  end

  AST_MASK_OPEN_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    setup_clr |=> (mask == '0) && !running); // R2
endmodule

// File: rtl/irq_ctrl8_reqcap.sv
module irq_ctrl8_reqcap
  import irq_ctrl8_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  line_vec_t irq_in,
  input  logic      level_mode,
  input  logic      setup_clr,
  input  line_vec_t take,
  output line_vec_t req_q
);
  line_vec_t prev_q;
  line_vec_t rise;

  assign rise = irq_in & ~prev_q;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q[g] <= 1'b0;
        req_q[g]  <= 1'b0;
      end else begin
        prev_q[g] <= irq_in[g];
        if (setup_clr)       req_q[g] <= 1'b0;
        else if (level_mode) req_q[g] <= irq_in[g];
        else if (take[g])    req_q[g] <= 1'b0;
        else if (rise[g])    req_q[g] <= 1'b1;
      end
    end
  end

  AST_EDGE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_mode && !setup_clr && take == '0) |=> ((req_q & $past(rise)) == $past(rise))); // R11
  AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_mode && !setup_clr && take == '0) |=> ((req_q & $past(req_q)) == $past(req_q))); // R11
endmodule

// File: rtl/irq_ctrl8_resolve.sv
module irq_ctrl8_resolve
  import irq_ctrl8_pkg::*;
(
  input  line_vec_t req,
  input  line_vec_t mask,
  input  line_vec_t svc,
  input  logic      running,
  output line_vec_t cand_oh,
  output line_idx_t cand_idx,
  output logic      cand_ok
);
  line_vec_t eligible;

  assign eligible = req & ~mask & above_service(svc);
  assign cand_oh  = running ? pick_lowest(eligible) : '0;
  assign cand_idx = onehot_to_idx(cand_oh);
  assign cand_ok  = running & (eligible != '0);
endmodule

// File: rtl/irq_ctrl8_svc.sv
module irq_ctrl8_svc
  import irq_ctrl8_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      setup_clr,
  input  logic      ack_take,
  input  line_vec_t cand_oh,
  input  logic      eoi_cmd,
  output line_vec_t svc_q
);
  line_vec_t svc_nxt;

  always_comb begin
    svc_nxt = svc_q;
    if (eoi_cmd)  svc_nxt = svc_nxt & ~pick_lowest(svc_q);
    if (ack_take) svc_nxt = svc_nxt | cand_oh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         svc_q <= '0;
    else if (setup_clr) svc_q <= '0;
    else                svc_q <= svc_nxt;
  end

  AST_EOI_DROPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_cmd && !ack_take && !setup_clr && svc_q != '0) |=>
      ($countones(svc_q) + 1 == $countones($past(svc_q)))); // R9
  AST_ACK_ENTERS_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_take && !setup_clr) |=> ((svc_q & $past(cand_oh)) == $past(cand_oh))); // R7
endmodule

// File: rtl/irq_ctrl8.sv
module irq_ctrl8
  import irq_ctrl8_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs,
  input  logic       rd,
  input  logic       wr,
  input  logic       addr_bit,
  input  logic [7:0] din,
  input  logic       iack,
  input  logic [7:0] irq_in,
  output logic [7:0] dout,
  output logic       dout_en,
  output logic       proc_irq
);
  logic      wr_stb;
  logic      rd_stb;
  logic      running;
  logic      level_mode;
  logic      auto_eoi;
  byte_t     base;
  line_vec_t mask;
  logic      rd_svc;
  logic      eoi_cmd;
  logic      setup_clr;
  line_vec_t req;
  line_vec_t svc;
  line_vec_t cand_oh;
  line_idx_t cand_idx;
  logic      cand_ok;
  logic      ack_hit;
  logic      ack_take;
  line_vec_t take;
  byte_t     vector;

  assign wr_stb   = cs & wr;
  assign rd_stb   = cs & rd;
  assign ack_hit  = iack & cand_ok;
  assign ack_take = ack_hit & ~auto_eoi;
  assign take     = ack_hit ? cand_oh : '0;
  assign vector   = vector_of(base, cand_ok ? cand_idx : line_idx_t'(LINES - 1));

  irq_ctrl8_cfg cfg_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_stb     (wr_stb),
    .addr_bit   (addr_bit),
    .din        (din),
    .running    (running),
    .level_mode (level_mode),
    .auto_eoi   (auto_eoi),
    .base       (base),
    .mask       (mask),
    .rd_svc     (rd_svc),
    .eoi_cmd    (eoi_cmd),
    .setup_clr  (setup_clr)
  );

  irq_ctrl8_reqcap reqcap_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_in     (irq_in),
    .level_mode (level_mode),
    .setup_clr  (setup_clr),
    .take       (take),
    .req_q      (req)
  );

  irq_ctrl8_resolve resolve_i (
    .req      (req),
    .mask     (mask),
    .svc      (svc),
    .running  (running),
    .cand_oh  (cand_oh),
    .cand_idx (cand_idx),
    .cand_ok  (cand_ok)
  );

  irq_ctrl8_svc svc_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .setup_clr (setup_clr),
    .ack_take  (ack_take),
    .cand_oh   (cand_oh),
    .eoi_cmd   (eoi_cmd),
    .svc_q     (svc)
  );

  always_comb begin
    if (iack)                  dout = vector;
    else if (rd_stb && addr_bit) dout = mask;
    else if (rd_stb)           dout = rd_svc ? svc : req;
    else                       dout = '0;
  end
  assign dout_en  = iack | rd_stb;
  assign proc_irq = cand_ok;

  AST_QUIET_UNTIL_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !proc_irq); // R2
  AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    proc_irq |-> ((req & ~mask) != '0)); // R5
  AST_AUTO_SVC_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (running && auto_eoi) |-> (svc == '0)); // R8
  AST_SPURIOUS_KEEPS_SVC: assert property (@(posedge clk) disable iff (!rst_n)
    (iack && !proc_irq && !wr_stb) |=> (svc == $past(svc))); // R12
  AST_VECTOR_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    iack |-> (byte_t'(dout - base) < byte_t'(LINES))); // R3
endmodule

// File: tb/irq_ctrl8_tb_top.sv
module irq_ctrl8_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0, rd = 1'b0, wr = 1'b0, addr_bit = 1'b0, iack = 1'b0;
  logic [7:0] din = '0;
  logic [7:0] irq = '0;
  logic [7:0] dout;
  logic       dout_en;
  logic       proc_irq;
  int         n_cmp = 0;
  int         n_bad = 0;
  logic [7:0] v;
  logic [7:0] base;

  always #4 clk = ~clk;

  irq_ctrl8 dut_i (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr_bit(addr_bit),
    .din(din), .iack(iack), .irq_in(irq), .dout(dout), .dout_en(dout_en),
    .proc_irq(proc_irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr_word(input logic a, input logic [7:0] d);
    @(negedge clk); cs = 1; wr = 1; addr_bit = a; din = d;
    @(negedge clk); cs = 0; wr = 0;
  endtask

  task automatic rd_word(input logic a, output logic [7:0] d);
    @(negedge clk); cs = 1; rd = 1; addr_bit = a;
    #1 d = dout;
    #1 cs = 0; rd = 0;
  endtask

  task automatic do_ack(output logic [7:0] d);
    @(negedge clk); iack = 1;
    #1 d = dout;
    @(negedge clk); iack = 0;
  endtask

  task automatic pulse(input logic [7:0] p);
    @(negedge clk); irq = p;
    @(negedge clk); irq = '0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 irq after reset", {7'b0, proc_irq}, 8'h00);
    rd_word(1, v); chk("R1 mask after reset", v, 8'hFF);
    rd_word(0, v); chk("R1 request after reset", v, 8'h00);

    // Edge, single, mode byte follows, commanded end.
    base = 8'h40;
    wr_word(0, 8'h13); wr_word(1, base); wr_word(1, 8'h01);
    rd_word(1, v); chk("R2 mask cleared", v, 8'h00);
    wr_word(0, 8'h0B);

    for (int p = 1; p < 256; p++) begin
      pulse(8'(p));
      for (int k = 0; k < 8; k++) begin
        if (p[k]) begin
          chk("R4 irq pending", {7'b0, proc_irq}, 8'h01);
          do_ack(v); chk("R4 vector order", v, base + 8'(k));
          rd_word(0, v); chk("R7 service bit", v, 8'(1 << k));
          wr_word(0, 8'h20);
        end
      end
      chk("R9 drained irq", {7'b0, proc_irq}, 8'h00);
      rd_word(0, v); chk("R9 service empty", v, 8'h00);
    end

    // Nesting.
    pulse(8'h20); do_ack(v); chk("R3 vector 5", v, 8'h45);
    pulse(8'h40); chk("R6 lower blocked", {7'b0, proc_irq}, 8'h00);
    pulse(8'h04); chk("R6 higher passes", {7'b0, proc_irq}, 8'h01);
    do_ack(v); chk("R6 nested vector", v, 8'h42);
    rd_word(0, v); chk("R6 nested service", v, 8'h24);
    wr_word(0, 8'h20);
    rd_word(0, v); chk("R9 lowest index cleared", v, 8'h20);
    chk("R6 still blocked", {7'b0, proc_irq}, 8'h00);
    wr_word(0, 8'h20);
    chk("R6 released", {7'b0, proc_irq}, 8'h01);
    do_ack(v); chk("R6 vector 6", v, 8'h46);
    wr_word(0, 8'h20);

    // Read selection.
    pulse(8'h0C); do_ack(v); chk("R3 vector 2", v, 8'h42);
    rd_word(0, v); chk("R10 service view", v, 8'h04);
    wr_word(0, 8'h08);
    rd_word(0, v); chk("R10 select unchanged", v, 8'h04);
    wr_word(0, 8'h0A);
    rd_word(0, v); chk("R10 request view", v, 8'h08);
    wr_word(0, 8'h0B);
    wr_word(0, 8'h20); do_ack(v); chk("R3 vector 3", v, 8'h43);
    wr_word(0, 8'h20);

    // Mask sweep with all lines pending.
    pulse(8'hFF);
    for (int m = 0; m < 256; m++) begin
      wr_word(1, 8'(m));
      chk("R5 mask gate", {7'b0, proc_irq}, (m != 255) ? 8'h01 : 8'h00);
      if (m % 51 == 0) begin
        rd_word(1, v); chk("R10 mask readback", v, 8'(m));
      end
    end
    wr_word(0, 8'h0A);
    rd_word(0, v); chk("R5 masked still recorded", v, 8'hFF);
    wr_word(0, 8'h0B);
    wr_word(1, 8'h00);
    for (int k = 0; k < 8; k++) begin
      do_ack(v); chk("R4 drain after mask", v, base + 8'(k));
      wr_word(0, 8'h20);
    end

    // Spurious acknowledge.
    do_ack(v); chk("R12 spurious vector", v, 8'h47);
    rd_word(0, v); chk("R12 service kept", v, 8'h00);
    wr_word(0, 8'h0A);
    rd_word(0, v); chk("R12 request kept", v, 8'h00);
    wr_word(0, 8'h0B);

    // Edge line held high.
    @(negedge clk); irq = 8'h01;
    @(negedge clk); do_ack(v); chk("R11 held vector", v, 8'h40);
    wr_word(0, 8'h20);
    repeat (3) @(negedge clk);
    chk("R11 held no refire", {7'b0, proc_irq}, 8'h00);
    @(negedge clk); irq = 8'h00;
    @(negedge clk); irq = 8'h01;
    @(negedge clk); chk("R11 new edge", {7'b0, proc_irq}, 8'h01);
    do_ack(v); wr_word(0, 8'h20);
    @(negedge clk); irq = 8'h00;

    // Cascaded, no mode byte: third word consumed.
    wr_word(0, 8'h10); wr_word(1, 8'h20); wr_word(1, 8'h55);
    rd_word(1, v); chk("R2 cascade byte consumed", v, 8'h00);
    pulse(8'h02); do_ack(v); chk("R3 base 20", v, 8'h21);
    wr_word(0, 8'h20);

    // Single, no mode byte: runs after the base.
    wr_word(0, 8'h12);
    pulse(8'h10); chk("R2 quiet during setup", {7'b0, proc_irq}, 8'h00);
    wr_word(1, 8'h30);
    chk("R2 running after base", {7'b0, proc_irq}, 8'h01);
    do_ack(v); chk("R3 base 30", v, 8'h34);
    wr_word(0, 8'h20);
    wr_word(1, 8'hAA);
    rd_word(1, v); chk("R2 first run write is mask", v, 8'hAA);

    // Level, automatic, base near wrap.
    wr_word(0, 8'h1B); wr_word(1, 8'hFC); wr_word(1, 8'h03);
    rd_word(1, v); chk("R2 mask cleared again", v, 8'h00);
    @(negedge clk); irq = 8'h80;
    @(negedge clk); chk("R11 level raises", {7'b0, proc_irq}, 8'h01);
    do_ack(v); chk("R3 vector wraps", v, 8'h03);
    chk("R11 level still pending", {7'b0, proc_irq}, 8'h01);
    wr_word(0, 8'h0B);
    rd_word(0, v); chk("R8 service untouched", v, 8'h00);
    @(negedge clk); irq = 8'h06;
    @(negedge clk); do_ack(v); chk("R3 level vector", v, 8'hFD);
    @(negedge clk); irq = 8'h00;
    @(negedge clk); chk("R11 level follows low", {7'b0, proc_irq}, 8'h00);
    wr_word(0, 8'h0A);
    rd_word(0, v); chk("R11 level request low", v, 8'h00);

    finish_run();
  end
endmodule